// File: doc/BRIEF.md
# Flash Write Bus Capture Interface

This block listens to a parallel, asynchronous NOR-flash style host bus and turns each host write cycle into a single-word command write inside the chip's own system clock domain. Every bus strobe passes through a two-stage synchronizer. The address and data buses travel through a matching two-stage pipeline, so each bus value stays lined up with the strobe samples it goes with. Edges are detected on the synchronized strobes.

How the address is latched depends on a mode input. In asynchronous mode the address is taken when the address-valid strobe rises. In synchronous read mode it is taken on a rising bus-clock edge seen while address-valid is low. If the bus clock stays low for the whole address-valid window, the address is taken when address-valid rises instead. Data is always taken when write enable rises.

A completed write leaves the block as a one-cycle `wr_valid` pulse, with the captured address and data on `wr_addr` and `wr_data`. If a write strobe arrives with no address latched since the previous data latch, the write is dropped and `proto_err` pulses instead. The block does not decode commands or read from the array.

Top module: `flash_wr_capture`

## Requirements
- R1: A bus edge takes part in a write only while the synchronized chip enable `bus_ce_n` is 0 and output enable `bus_oe_n` is 1. A write-enable rise that does not meet this condition is ignored: it gives no `wr_valid`, no `proto_err`, and leaves any latched address pending.
- R2: With `mode_async`=1, the address is captured from `bus_addr` at the rising edge of `bus_adv_n`.
- R3: In both modes, the data word is captured from `bus_data` at the rising edge of `bus_we_n`.
- R4: With `mode_async`=0, the address is captured on a rising edge of `bus_clk` that occurs while `bus_adv_n` is 0. A later rise of `bus_adv_n` in the same window does not replace that address.
- R5: With `mode_async`=0, if `bus_clk` stays 0 for the whole time `bus_adv_n` is low, the address is captured at the rising edge of `bus_adv_n`.
- R6: Each accepted write produces exactly one `wr_valid` pulse, one system clock wide. `wr_addr` and `wr_data` hold the captured word and change only when `wr_valid` is high.
- R7: A write-enable rise that meets R1, with no address latched since the previous data latch, produces a one-cycle `proto_err` pulse and no `wr_valid`. `wr_addr` and `wr_data` keep their values.
- R8: With `mode_async`=1, rising edges of `bus_clk` capture nothing. The address comes only from the rising edge of `bus_adv_n`.
- R9: After reset, `wr_valid`=0, `proto_err`=0, `wr_addr`=0 and `wr_data`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_async | input | 1 | 1: address taken on address-valid rise; 0: synchronous read mode |
| bus_clk | input | 1 | Host bus clock (may be held low) |
| bus_ce_n | input | 1 | Chip enable, active low |
| bus_we_n | input | 1 | Write enable, active low |
| bus_oe_n | input | 1 | Output enable, active low |
| bus_adv_n | input | 1 | Address-valid strobe, active low |
| bus_addr | input | ADDR_W | Host address bus |
| bus_data | input | DATA_W | Host data bus |
| wr_valid | output | 1 | One-cycle pulse per accepted write |
| wr_addr | output | ADDR_W | Captured address |
| wr_data | output | DATA_W | Captured data word |
| proto_err | output | 1 | One-cycle pulse for a write with no latched address |

## Verification
The bench builds the block with the default widths: 24 address bits and 16 data bits. It uses addresses with the top bit set, and data words of all ones and all zeros, so a truncated or shifted field shows up in the captured word. Every bus phase lasts four system clocks. This keeps the two-stage pipeline short compared with the strobe widths. It also allows the address on the bus to change between a bus-clock rise and the following address-valid rise, so a capture taken at the wrong event gives the wrong address.

// File: rtl/flash_wr_capture.sv
module flash_wr_capture #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_async,
  input  logic              bus_clk,
  input  logic              bus_ce_n,
  input  logic              bus_we_n,
  input  logic              bus_oe_n,
  input  logic              bus_adv_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              proto_err
);
  localparam int SW = 5;
  localparam int VW = SW + ADDR_W + DATA_W;
  localparam logic [SW-1:0] IDLE = 5'b01111;

  logic [VW-1:0] raw, st1, st2;
  logic [SW-1:0] prev;

  assign raw = {bus_clk, bus_adv_n, bus_oe_n, bus_we_n, bus_ce_n, bus_addr, bus_data};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st1  <= {IDLE, {(ADDR_W + DATA_W){1'b0}}};
      st2  <= {IDLE, {(ADDR_W + DATA_W){1'b0}}};
      prev <= IDLE;
    end else begin
      st1  <= raw;
      st2  <= st1;
      prev <= st2[VW-1 -: SW];
    end
  end

  logic              clk_s, adv_s, oe_s, we_s, ce_s;
  logic              clk_q, adv_q, we_q;
  logic [ADDR_W-1:0] addr_s;
  logic [DATA_W-1:0] data_s;

  assign {clk_s, adv_s, oe_s, we_s, ce_s} = st2[VW-1 -: SW];
  assign addr_s = st2[DATA_W +: ADDR_W];
  assign data_s = st2[DATA_W-1:0];
  assign clk_q  = prev[4];
  assign adv_q  = prev[3];
  assign we_q   = prev[1];

  logic sel, adv_rise, clk_rise, we_rise;
  assign sel      = ~ce_s & oe_s;
  assign adv_rise = adv_s & ~adv_q;
  assign clk_rise = clk_s & ~clk_q;
  assign we_rise  = we_s & ~we_q;

  logic clk_seen, pend;
  logic lat_clk, lat_adv, lat_addr, lat_data, fire;
  logic [ADDR_W-1:0] addr_hold;

  assign lat_clk  = ~mode_async & sel & clk_rise & ~adv_s;
  assign lat_adv  = sel & adv_rise & (mode_async | (~clk_seen & ~clk_s));
  assign lat_addr = lat_clk | lat_adv;
  assign lat_data = sel & we_rise;
  assign fire     = lat_data & (pend | lat_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_seen  <= 1'b0;
      pend      <= 1'b0;
      addr_hold <= '0;
    end else begin
      if (adv_s)        clk_seen <= 1'b0;
      else if (lat_clk) clk_seen <= 1'b1;
      if (lat_addr) addr_hold <= addr_s;
      if (lat_data)      pend <= 1'b0;
      else if (lat_addr) pend <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid  <= 1'b0;
      proto_err <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
    end else begin
      wr_valid  <= fire;
      proto_err <= lat_data & ~fire;
      if (fire) begin
        wr_addr <= lat_addr ? addr_s : addr_hold;
        wr_data <= data_s;
      end
    end
  end

  p_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |-> ($stable(wr_addr) && $stable(wr_data)));
  p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid && proto_err));
  p_we_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid || proto_err) |-> $past(we_s && !we_q));
  p_selected_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid || proto_err) |-> $past(!ce_s && oe_s));
endmodule

// File: tb/flash_wr_capture_test.sv
`timescale 1ns/1ps
module flash_wr_capture_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic mode_async = 1'b1, bus_clk = 1'b0;
  logic bus_ce_n = 1'b1, bus_we_n = 1'b1, bus_oe_n = 1'b1, bus_adv_n = 1'b1;
  logic [23:0] bus_addr = '0;
  logic [15:0] bus_data = '0;
  logic wr_valid, proto_err;
  logic [23:0] wr_addr;
  logic [15:0] wr_data;

  int n_cmp = 0, n_bad = 0;
  int vcnt = 0, ecnt = 0, hicnt = 0;
  logic vprev = 1'b0, eprev = 1'b0;

  always #2 clk = ~clk;

  flash_wr_capture uut (
    .clk(clk), .rst_n(rst_n), .mode_async(mode_async), .bus_clk(bus_clk),
    .bus_ce_n(bus_ce_n), .bus_we_n(bus_we_n), .bus_oe_n(bus_oe_n),
    .bus_adv_n(bus_adv_n), .bus_addr(bus_addr), .bus_data(bus_data),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .proto_err(proto_err)
  );

  always @(negedge clk) begin
    if (wr_valid && !vprev) vcnt++;
    if (proto_err && !eprev) ecnt++;
    if (wr_valid) hicnt++;
    vprev = wr_valid;
    eprev = proto_err;
  end

  task automatic chk(input string req, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [23:0] a1, input logic [23:0] a2,
                           input logic [15:0] d, input bit tog);
    bus_ce_n = 1'b0; bus_oe_n = 1'b1; bus_adv_n = 1'b0; bus_addr = a1;
    cycles(4);
    if (tog) begin bus_clk = 1'b1; cycles(4); bus_clk = 1'b0; end
    bus_addr = a2; cycles(4);
    bus_adv_n = 1'b1; cycles(4);
    bus_addr = 24'h0; bus_data = d; bus_we_n = 1'b0; cycles(4);
    bus_we_n = 1'b1; cycles(4);
    bus_ce_n = 1'b1; cycles(6);
  endtask

  task automatic addr_only(input logic [23:0] a);
    bus_ce_n = 1'b0; bus_oe_n = 1'b1; bus_adv_n = 1'b0; bus_addr = a; cycles(4);
    bus_adv_n = 1'b1; cycles(4);
    bus_ce_n = 1'b1; cycles(4);
  endtask

  task automatic we_only(input logic [15:0] d, input logic ce, input logic oe);
    bus_ce_n = ce; bus_oe_n = oe; bus_data = d; cycles(4);
    bus_we_n = 1'b0; cycles(4);
    bus_we_n = 1'b1; cycles(4);
    bus_ce_n = 1'b1; bus_oe_n = 1'b1; cycles(6);
  endtask

  task automatic t_reset;
    chk("R9 wr_valid", wr_valid, 0);
    chk("R9 proto_err", proto_err, 0);
    chk("R9 wr_addr", wr_addr, 0);
    chk("R9 wr_data", wr_data, 0);
  endtask

  task automatic t_async;
    int v0 = vcnt, e0 = ecnt;
    mode_async = 1'b1;
    bus_write(24'h111111, 24'h812345, 16'hFFFF, 1'b0);
    chk("R6 pulse count", vcnt - v0, 1);
    chk("R2 async addr", wr_addr, 24'h812345);
    chk("R3 data async", wr_data, 16'hFFFF);
    chk("R7 no error", ecnt - e0, 0);
  endtask

  task automatic t_async_clk;
    int v0 = vcnt;
    mode_async = 1'b1;
    bus_write(24'h0AAAAA, 24'hF0F0F0, 16'h0000, 1'b1);
    chk("R8 pulse", vcnt - v0, 1);
    chk("R8 clock ignored", wr_addr, 24'hF0F0F0);
    chk("R3 data zero", wr_data, 16'h0000);
  endtask

  task automatic t_sync_clk;
    int v0 = vcnt;
    mode_async = 1'b0;
    bus_write(24'hC00001, 24'h3FFFFE, 16'hA5C3, 1'b1);
    chk("R4 pulse", vcnt - v0, 1);
    chk("R4 clock addr", wr_addr, 24'hC00001);
    chk("R3 data sync", wr_data, 16'hA5C3);
  endtask

  task automatic t_sync_low;
    int v0 = vcnt;
    mode_async = 1'b0;
    bus_write(24'h000123, 24'hFEDCBA, 16'h5A5A, 1'b0);
    chk("R5 pulse", vcnt - v0, 1);
    chk("R5 held-low addr", wr_addr, 24'hFEDCBA);
    mode_async = 1'b1;
  endtask

  task automatic t_no_addr;
    int v0 = vcnt, e0 = ecnt;
    logic [23:0] a0 = wr_addr;
    logic [15:0] d0 = wr_data;
    we_only(16'h1357, 1'b0, 1'b1);
    chk("R7 error pulse", ecnt - e0, 1);
    chk("R7 no valid", vcnt - v0, 0);
    chk("R7 addr kept", wr_addr, a0);
    chk("R7 data kept", wr_data, d0);
  endtask

  task automatic t_select;
    int v0 = vcnt, e0 = ecnt;
    mode_async = 1'b1;
    addr_only(24'h9ABCDE);
    we_only(16'h1111, 1'b0, 1'b0);
    chk("R1 oe low no valid", vcnt - v0, 0);
    chk("R1 oe low no error", ecnt - e0, 0);
    we_only(16'h2222, 1'b1, 1'b1);
    chk("R1 ce high no valid", vcnt - v0, 0);
    chk("R1 ce high no error", ecnt - e0, 0);
    we_only(16'h3333, 1'b0, 1'b1);
    chk("R1 pending kept valid", vcnt - v0, 1);
    chk("R1 pending addr", wr_addr, 24'h9ABCDE);
    chk("R1 data", wr_data, 16'h3333);
  endtask

  initial begin
    cycles(3);
    t_reset();
    rst_n = 1'b1;
    cycles(4);
    t_async();
    t_async_clk();
    t_sync_clk();
    t_sync_low();
    t_no_addr();
    t_select();
    chk("R6 single-cycle width", hicnt, vcnt);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule